// File: doc/BRIEF.md
# Overlay Plane Colour-Key Comparator

This block decides, pixel by pixel, whether an overlay plane's pixel or the primary-plane pixel beneath it reaches the compositor output. Each pixel has three 8-bit channels. Channel i sits at bits [8i+7:8i]. A key is made of three parts: a lower bound colour, an upper bound colour and a 3-bit channel enable. Each channel is compared against its own inclusive window.

There are three key modes. With keying off, the overlay always shows. In source mode, overlay pixels that fall inside the key window become transparent. In destination mode, the overlay shows only where the underlying pixel falls inside the window.

Configuration is written into a staging copy. A write that asks for an illegal mode is rejected. The staged copy moves to the active copy only on a frame-start pulse, so no frame ever mixes two key settings. The block also gates a "hides the layer below" hint: whenever keying is active, the hint is forced low.

Top module: `ovl_ckey_top`

## Requirements
- R1: A channel matches when its enable bit (bit i for channel i) is set and lower[i] <= value[i] <= upper[i], both bounds inclusive. A channel whose enable bit is clear always matches. A pixel matches when all three channels match.
- R2: With the active mode off (no source or destination request on the last accepted write), `out_sel_ovl` is 1 and `out_pix` is the overlay pixel.
- R3: In source mode, a matching overlay pixel yields `out_sel_ovl`=0 with the base pixel on `out_pix`; a non-matching overlay pixel yields `out_sel_ovl`=1 with the overlay pixel on `out_pix`.
- R4: In destination mode, `out_sel_ovl`=1 and the overlay pixel are output only when the base pixel matches; otherwise `out_sel_ovl`=0 and the base pixel are output.
- R5: `out_valid` is high exactly one cycle after a cycle in which both `ovl_valid` and `base_valid` were high. `out_pix` and `out_sel_ovl` are registered in that same cycle.
- R6: A configuration write requesting both source and destination keying is rejected. `cfg_reject` is high in the next cycle, and every staged value (bounds, enables, mode) is left unchanged.
- R7: When the build parameter `DEST_KEY_EN` is 0, a write requesting destination keying is rejected in the same way as in R6, and destination mode can never become active.
- R8: Staged configuration becomes active only at a clock edge where `frame_start` is high. Pixels processed before that edge still use the previous active setting.
- R9: `hides_below` equals `ovl_covers_all` while the active mode is off, and is 0 while any key mode is active.
- R10: `out_pix` always equals the overlay or the base pixel from the previous cycle, as selected by `out_sel_ovl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_lower | input | 24 | Key lower bound colour |
| cfg_upper | input | 24 | Key upper bound colour |
| cfg_chan_en | input | 3 | Per-channel compare enable |
| cfg_src_req | input | 1 | Request source keying |
| cfg_dst_req | input | 1 | Request destination keying |
| cfg_reject | output | 1 | Last write was rejected |
| frame_start | input | 1 | Applies staged configuration |
| ovl_covers_all | input | 1 | Overlay covers the whole screen |
| hides_below | output | 1 | Overlay may hide the base layer |
| ovl_valid | input | 1 | Overlay pixel valid |
| ovl_pix | input | 24 | Overlay pixel |
| base_valid | input | 1 | Base pixel valid |
| base_pix | input | 24 | Base (primary) pixel |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 24 | Selected pixel |
| out_sel_ovl | output | 1 | 1 when the overlay pixel was chosen |

## Verification
The assertions assume that pixel inputs are meaningful only when both valid flags are high together, and that `frame_start` is a one-cycle pulse. The selection checks look one cycle into the past and therefore rely on the active mode being sampled in the same cycle as the pixel pair. The stimulus drives overlay and base pixels as matched pairs with both valids raised together. It issues configuration writes and frame pulses in cycles separate from pixel pairs, except where the ordering rule of R8 is the subject of the test.

// File: rtl/ckey_pkg.sv
package ckey_pkg;
  localparam int CHANS   = 3;
  localparam int CH_W    = 8;
  localparam int PIX_W   = CHANS * CH_W;

  typedef enum logic [1:0] {
    KM_OFF = 2'd0,
    KM_SRC = 2'd1,
    KM_DST = 2'd2
  } key_mode_e;

  typedef struct packed {
    logic [PIX_W-1:0] lower;
    logic [PIX_W-1:0] upper;
    logic [CHANS-1:0] chan_en;
    key_mode_e        mode;
  } key_cfg_t;

  // Inclusive window test for one channel; disabled channel always matches.
  function automatic logic chan_in_window(input logic [CH_W-1:0] v,
                                          input logic [CH_W-1:0] lo,
                                          input logic [CH_W-1:0] hi,
                                          input logic            en);
    return !en || ((v >= lo) && (v <= hi));
  endfunction

  // Does the overlay pixel reach the output?
  function automatic logic choose_overlay(input key_mode_e m,
                                          input logic ovl_hit,
                                          input logic base_hit);
    case (m)
      KM_SRC:  return !ovl_hit;
      KM_DST:  return base_hit;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/ckey_cfg_regs.sv
module ckey_cfg_regs
  import ckey_pkg::*;
#(
  parameter bit DEST_KEY_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [PIX_W-1:0] lower,
  input  logic [PIX_W-1:0] upper,
  input  logic [CHANS-1:0] chan_en,
  input  logic             src_req,
  input  logic             dst_req,
  input  logic             frame_start,
  output key_cfg_t         staged,
  output key_cfg_t         active,
  output logic             reject
);
  logic      bad_combo;
  logic      bad_dest;
  logic      accept;
  key_mode_e req_mode;

  assign bad_combo = src_req && dst_req;
  assign bad_dest  = dst_req && !DEST_KEY_EN;
  assign accept    = wr && !bad_combo && !bad_dest;

  always_comb begin
    if (src_req)      req_mode = KM_SRC;
    else if (dst_req) req_mode = KM_DST;
    else              req_mode = KM_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= '{lower: '0, upper: '0, chan_en: '0, mode: KM_OFF};
      active <= '{lower: '0, upper: '0, chan_en: '0, mode: KM_OFF};
      reject <= 1'b0;
    end else begin
      reject <= wr && (bad_combo || bad_dest);
      if (accept) begin
        staged.lower   <= lower;
        staged.upper   <= upper;
        staged.chan_en <= chan_en;
        staged.mode    <= req_mode;
      end
      if (frame_start) active <= staged;
    end
  end
endmodule

// File: rtl/ckey_match.sv
module ckey_match
  import ckey_pkg::*;
(
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] lower,
  input  logic [PIX_W-1:0] upper,
  input  logic [CHANS-1:0] chan_en,
  output logic [CHANS-1:0] chan_hit,
  output logic             hit
);
  for (genvar i = 0; i < CHANS; i++) begin : g_chan
    assign chan_hit[i] = chan_in_window(pix[i*CH_W +: CH_W],
                                        lower[i*CH_W +: CH_W],
                                        upper[i*CH_W +: CH_W],
                                        chan_en[i]);
  end
  assign hit = &chan_hit;
endmodule

// File: rtl/ckey_select.sv
module ckey_select
  import ckey_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  key_mode_e        mode,
  input  logic             ovl_valid,
  input  logic [PIX_W-1:0] ovl_pix,
  input  logic             ovl_hit,
  input  logic             base_valid,
  input  logic [PIX_W-1:0] base_pix,
  input  logic             base_hit,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_sel_ovl
);
  logic pick_ovl;
  assign pick_ovl = choose_overlay(mode, ovl_hit, base_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_pix     <= '0;
      out_sel_ovl <= 1'b0;
    end else begin
      out_valid   <= ovl_valid && base_valid;
      out_sel_ovl <= pick_ovl;
      out_pix     <= pick_ovl ? ovl_pix : base_pix;
    end
  end
endmodule

// File: rtl/ovl_ckey_top.sv
module ovl_ckey_top
  import ckey_pkg::*;
#(
  parameter bit DEST_KEY_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [PIX_W-1:0] cfg_lower,
  input  logic [PIX_W-1:0] cfg_upper,
  input  logic [CHANS-1:0] cfg_chan_en,
  input  logic             cfg_src_req,
  input  logic             cfg_dst_req,
  output logic             cfg_reject,
  input  logic             frame_start,
  input  logic             ovl_covers_all,
  output logic             hides_below,
  input  logic             ovl_valid,
  input  logic [PIX_W-1:0] ovl_pix,
  input  logic             base_valid,
  input  logic [PIX_W-1:0] base_pix,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_sel_ovl
);
  key_cfg_t         stg_cfg;
  key_cfg_t         act_cfg;
  logic [1:0]       stg_mode;
  logic [1:0]       act_mode;
  logic [CHANS-1:0] ovl_chan_hit;
  logic [CHANS-1:0] base_chan_hit;
  logic             ovl_hit;
  logic             base_hit;

  ckey_cfg_regs #(.DEST_KEY_EN(DEST_KEY_EN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
    .lower(cfg_lower), .upper(cfg_upper), .chan_en(cfg_chan_en),
    .src_req(cfg_src_req), .dst_req(cfg_dst_req),
    .frame_start(frame_start),
    .staged(stg_cfg), .active(act_cfg), .reject(cfg_reject)
  );

  assign stg_mode = stg_cfg.mode;
  assign act_mode = act_cfg.mode;

  ckey_match u_ovl_match (
    .pix(ovl_pix), .lower(act_cfg.lower), .upper(act_cfg.upper),
    .chan_en(act_cfg.chan_en), .chan_hit(ovl_chan_hit), .hit(ovl_hit)
  );

  ckey_match u_base_match (
    .pix(base_pix), .lower(act_cfg.lower), .upper(act_cfg.upper),
    .chan_en(act_cfg.chan_en), .chan_hit(base_chan_hit), .hit(base_hit)
  );

  ckey_select u_sel (
    .clk(clk), .rst_n(rst_n), .mode(act_cfg.mode),
    .ovl_valid(ovl_valid), .ovl_pix(ovl_pix), .ovl_hit(ovl_hit),
    .base_valid(base_valid), .base_pix(base_pix), .base_hit(base_hit),
    .out_valid(out_valid), .out_pix(out_pix), .out_sel_ovl(out_sel_ovl)
  );

  assign hides_below = ovl_covers_all && (act_cfg.mode == KM_OFF);
endmodule

// File: rtl/ckey_chk.sv
module ckey_chk #(
  parameter bit DEST_KEY_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        cfg_src_req,
  input logic        cfg_dst_req,
  input logic        cfg_reject,
  input logic        frame_start,
  input logic        ovl_covers_all,
  input logic        hides_below,
  input logic        ovl_valid,
  input logic [23:0] ovl_pix,
  input logic        base_valid,
  input logic [23:0] base_pix,
  input logic        out_valid,
  input logic [23:0] out_pix,
  input logic        out_sel_ovl,
  input logic [1:0]  stg_mode,
  input logic [1:0]  act_mode
);
  AST_BOTH_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_src_req && cfg_dst_req) |=> cfg_reject);  // R6
  AST_REJECT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_src_req && cfg_dst_req) |=> $stable(stg_mode));  // R6
  AST_NO_DEST_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !DEST_KEY_EN |-> (act_mode != 2'd2));  // R7
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_mode));  // R8
  AST_VALID_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_valid && base_valid) |=> out_valid);  // R5
  AST_VALID_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovl_valid && base_valid) |=> !out_valid);  // R5
  AST_KEYED_NO_HIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode != 2'd0) |-> !hides_below);  // R9
  AST_OFF_SHOWS_OVL: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_valid && base_valid && act_mode == 2'd0) |=> out_sel_ovl);  // R2
  AST_PIX_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_valid && base_valid) |=>
      (out_pix == (out_sel_ovl ? $past(ovl_pix) : $past(base_pix))));  // R10
endmodule

bind ovl_ckey_top ckey_chk #(.DEST_KEY_EN(DEST_KEY_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
  .cfg_src_req(cfg_src_req), .cfg_dst_req(cfg_dst_req),
  .cfg_reject(cfg_reject), .frame_start(frame_start),
  .ovl_covers_all(ovl_covers_all), .hides_below(hides_below),
  .ovl_valid(ovl_valid), .ovl_pix(ovl_pix),
  .base_valid(base_valid), .base_pix(base_pix),
  .out_valid(out_valid), .out_pix(out_pix), .out_sel_ovl(out_sel_ovl),
  .stg_mode(stg_mode), .act_mode(act_mode)
);

// File: tb/ovl_ckey_top_tb.sv
module ovl_ckey_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [23:0] cfg_lower = '0;
  logic [23:0] cfg_upper = '0;
  logic [2:0]  cfg_chan_en = '0;
  logic        cfg_src_req = 1'b0;
  logic        cfg_dst_req = 1'b0;
  logic        frame_start = 1'b0;
  logic        ovl_covers_all = 1'b0;
  logic        ovl_valid = 1'b0;
  logic [23:0] ovl_pix = '0;
  logic        base_valid = 1'b0;
  logic [23:0] base_pix = '0;

  logic        cfg_reject, hides_below, out_valid, out_sel_ovl;
  logic [23:0] out_pix;
  logic        n_reject, n_hides, n_valid, n_sel;
  logic [23:0] n_pix;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of configuration: 0 off, 1 source, 2 destination
  logic [23:0] m_lo, m_hi, s_lo, s_hi;
  logic [2:0]  m_en, s_en;
  int          m_mode, s_mode, n_mode, ns_mode;

  always #4 clk = ~clk;

  ovl_ckey_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_lower(cfg_lower),
    .cfg_upper(cfg_upper), .cfg_chan_en(cfg_chan_en),
    .cfg_src_req(cfg_src_req), .cfg_dst_req(cfg_dst_req),
    .cfg_reject(cfg_reject), .frame_start(frame_start),
    .ovl_covers_all(ovl_covers_all), .hides_below(hides_below),
    .ovl_valid(ovl_valid), .ovl_pix(ovl_pix), .base_valid(base_valid),
    .base_pix(base_pix), .out_valid(out_valid), .out_pix(out_pix),
    .out_sel_ovl(out_sel_ovl)
  );

  ovl_ckey_top #(.DEST_KEY_EN(1'b0)) u_dut_nodst (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_lower(cfg_lower),
    .cfg_upper(cfg_upper), .cfg_chan_en(cfg_chan_en),
    .cfg_src_req(cfg_src_req), .cfg_dst_req(cfg_dst_req),
    .cfg_reject(n_reject), .frame_start(frame_start),
    .ovl_covers_all(ovl_covers_all), .hides_below(n_hides),
    .ovl_valid(ovl_valid), .ovl_pix(ovl_pix), .base_valid(base_valid),
    .base_pix(base_pix), .out_valid(n_valid), .out_pix(n_pix),
    .out_sel_ovl(n_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit key_hit(input logic [23:0] p);
    bit h = 1'b1;
    for (int c = 0; c < 3; c++) begin
      int v  = int'(p[c*8 +: 8]);
      int lo = int'(m_lo[c*8 +: 8]);
      int hi = int'(m_hi[c*8 +: 8]);
      if (m_en[c] && (v < lo || v > hi)) h = 1'b0;
    end
    return h;
  endfunction

  function automatic bit model_pick(input int mode, input logic [23:0] o, input logic [23:0] b);
    if (mode == 1) return !key_hit(o);
    if (mode == 2) return key_hit(b);
    return 1'b1;
  endfunction

  task automatic write_cfg(input logic [23:0] lo, input logic [23:0] hi,
                           input logic [2:0] en, input bit src, input bit dst,
                           input string req);
    bit rej  = src && dst;
    bit nrej = rej || dst;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_lower = lo; cfg_upper = hi; cfg_chan_en = en;
    cfg_src_req = src; cfg_dst_req = dst;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_src_req = 1'b0; cfg_dst_req = 1'b0;
    check(req, {31'd0, cfg_reject}, {31'd0, rej});
    check("R7", {31'd0, n_reject}, {31'd0, nrej});
    if (!rej) begin
      s_lo = lo; s_hi = hi; s_en = en;
      s_mode = src ? 1 : (dst ? 2 : 0);
    end
    if (!nrej) ns_mode = src ? 1 : 0;
  endtask

  task automatic do_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    m_lo = s_lo; m_hi = s_hi; m_en = s_en; m_mode = s_mode; n_mode = ns_mode;
  endtask

  task automatic pixel(input logic [23:0] o, input logic [23:0] b, input string req);
    bit pk = model_pick(m_mode, o, b);
    @(negedge clk);
    ovl_valid = 1'b1; base_valid = 1'b1; ovl_pix = o; base_pix = b;
    @(negedge clk);
    ovl_valid = 1'b0; base_valid = 1'b0;
    check("R5", {31'd0, out_valid}, 32'd1);
    check(req, {31'd0, out_sel_ovl}, {31'd0, pk});
    check("R10", {8'd0, out_pix}, {8'd0, pk ? o : b});
  endtask

  task automatic t_reset();
    check("R5", {31'd0, out_valid}, 32'd0);
    check("R6", {31'd0, cfg_reject}, 32'd0);
  endtask

  task automatic t_off_mode();
    write_cfg(24'h102030, 24'h405060, 3'b111, 1'b0, 1'b0, "R6");
    do_frame();
    pixel(24'h304050, 24'h304050, "R2");
    pixel(24'hFFFFFF, 24'h000000, "R2");
    ovl_covers_all = 1'b1;
    @(negedge clk);
    check("R9", {31'd0, hides_below}, 32'd1);
  endtask

  task automatic t_source();
    write_cfg(24'h102030, 24'h405060, 3'b111, 1'b1, 1'b0, "R6");
    do_frame();
    check("R9", {31'd0, hides_below}, 32'd0);
    pixel(24'h304050, 24'hAAAAAA, "R3");  // inside window
    pixel(24'h102030, 24'hAAAAAA, "R1");  // lower edge inclusive
    pixel(24'h405060, 24'hAAAAAA, "R1");  // upper edge inclusive
    pixel(24'h405061, 24'hAAAAAA, "R1");  // channel 0 one above
    pixel(24'h0F2030, 24'hAAAAAA, "R1");  // channel 2 one below
    pixel(24'h9999FF, 24'h123456, "R3");
  endtask

  task automatic t_mask();
    write_cfg(24'h102030, 24'h405060, 3'b110, 1'b1, 1'b0, "R6");
    do_frame();
    pixel(24'h4050FF, 24'h777777, "R1");  // channel 0 disabled
    pixel(24'h4051FF, 24'h777777, "R1");  // channel 1 out
  endtask

  task automatic t_dest();
    write_cfg(24'h000000, 24'h0F0F0F, 3'b111, 1'b0, 1'b1, "R6");
    // R8: before frame, source setting still in force
    pixel(24'h304050, 24'h050505, "R8");
    do_frame();
    pixel(24'hABCDEF, 24'h050505, "R4");
    pixel(24'hABCDEF, 24'h100505, "R4");
    check("R9", {31'd0, hides_below}, 32'd0);
    // R7: unit without destination keying stayed in prior mode
    check("R7", {31'd0, n_hides}, {31'd0, n_mode == 0});
  endtask

  task automatic t_reject();
    write_cfg(24'hFFFFFF, 24'hFFFFFF, 3'b111, 1'b1, 1'b1, "R6");
    do_frame();
    pixel(24'hABCDEF, 24'h050505, "R6");  // still destination, old window
    pixel(24'hFFFFFF, 24'hFFFFFF, "R6");
  endtask

  task automatic t_valid_gap();
    @(negedge clk);
    ovl_valid = 1'b1; base_valid = 1'b0;
    @(negedge clk);
    ovl_valid = 1'b0;
    check("R5", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_lo = '0; m_hi = '0; m_en = '0; m_mode = 0;
    s_lo = '0; s_hi = '0; s_en = '0; s_mode = 0;
    n_mode = 0; ns_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off_mode();
    t_source();
    t_mask();
    t_dest();
    t_reject();
    t_valid_gap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule